// File: doc/BRIEF.md
# Event Timestamp Capture Slice

This block is one channel of an event timestamping unit. It watches one source, picked by a select field from a set of general-purpose input pins, a software-written trigger level and an internal periodic timer. On an enabled edge of that source it records two time bases in the same clock cycle: a free-running seconds/nanoseconds counter and a 56-bit global counter. Each record also carries a descriptor word. Records go into a small first-in first-out store, and an interrupt is raised while records are pending.

Software configures the slice and reads the oldest record through a simple register port. Reading the descriptor word retires that record. Writing a fixed flush code empties the store. A chip places copies of the slice at a 4 KiB stride and decodes the slice number above the 12 offset bits. Both counters come from outside as inputs. The pins pass through a two-flop synchroniser inside the slice.

Top module: `evt_stamp_slice`

## Requirements
- R1: After reset the configuration (offset 0x00), status (0x04), all stamp words and the descriptor read zero, and `irq` is low.
- R2: With configuration bit 0 set, a rising edge of the source selected by configuration bits 9:4 stores a record. Select values 0 to N_GPIO-1 name a pin. The recorded counters are the values present at the third rising clock edge at or after the pin change.
- R3: With configuration bit 1 set, a falling edge stores a record. Descriptor bit 8 is 1 for a rising edge and 0 for a falling edge, and descriptor bits 5:0 hold the select value.
- R4: Configuration bit 17 enables storing the seconds/nanoseconds stamp and bit 16 enables storing the global stamp. A stamp whose enable was clear reads zero, and descriptor bits 17 and 16 show which stamps were stored.
- R5: The global stamp reads as a high word at 0x1C holding counter bits 55:24 and a low word at 0x18 holding counter bits 23:0 in bits 31:8, with bits 7:0 zero. Nanoseconds read at 0x10 and seconds at 0x14.
- R6: Status bits 5:0 give the number of pending records. `irq` is high exactly when configuration bit 31 is set and that number is nonzero.
- R7: Stamp reads return the oldest pending record. A read of the descriptor at 0x20 removes that record. With nothing pending, these reads return zero and change nothing.
- R8: At most DEPTH (4) records are held. An event that arrives while the store is full is dropped and sets the sticky status bit 8.
- R9: Writing a value whose bits 2:0 are 0b111 to 0x24 empties the store and clears status bit 8. Any other value written there has no effect.
- R10: Select value 62 takes bit 0 of the software trigger register at 0x28 as the source.
- R11: Select value 63 takes the internal timer. With period P of 2 or more at 0x2C it yields one event every P cycles. P equal to 0 stops it.
- R12: Select values from N_GPIO to 61 never produce a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | N_GPIO | Asynchronous event pins |
| ts_sec | input | 32 | Time-stamp counter, seconds |
| ts_nsec | input | 32 | Time-stamp counter, nanoseconds |
| gcnt | input | 56 | Global counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset inside the slice window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Slice interrupt |

## Verification
The hardest situation to reach is an event that arrives while the store is full, in the same cycle as a retiring read or a flush. Whether that event is kept depends on exact cycle alignment through the synchroniser. The bench drives bursts of pin pulses and periodic timer events past the store depth while reads are in progress. A behavioural queue model steps on every clock and predicts the pending count, the overflow flag and each returned word, so drops and retirements that coincide at one edge are compared exactly.

// File: rtl/evt_stamp_pkg.sv
`timescale 1ns/1ps
package evt_stamp_pkg;
   localparam int SEL_W    = 6;
   localparam int GC_W     = 56;
   localparam logic [SEL_W-1:0] SEL_SOFT  = 6'd62;
   localparam logic [SEL_W-1:0] SEL_TIMER = 6'd63;

   // configuration bit positions (decoded by software)
   localparam int B_RISE   = 0;
   localparam int B_FALL   = 1;
   localparam int B_SEL    = 4;
   localparam int B_GC_EN  = 16;
   localparam int B_TS_EN  = 17;
   localparam int B_IRQ_EN = 31;
   localparam logic [31:0] CFG_MASK = 32'h8003_03F3;

   // register offsets inside one slice window
   localparam int OFS_CFG    = 'h00;
   localparam int OFS_STAT   = 'h04;
   localparam int OFS_TS_NS  = 'h10;
   localparam int OFS_TS_S   = 'h14;
   localparam int OFS_GC_LO  = 'h18;
   localparam int OFS_GC_HI  = 'h1C;
   localparam int OFS_KIND   = 'h20;
   localparam int OFS_FLUSH  = 'h24;
   localparam int OFS_SOFT   = 'h28;
   localparam int OFS_PERIOD = 'h2C;

   typedef struct packed {
      logic [31:0]      sec;
      logic [31:0]      nsec;
      logic [31:0]      gc_hi;
      logic [23:0]      gc_lo;
      logic             ts_ok;
      logic             gc_ok;
      logic             rise;
      logic [SEL_W-1:0] sel;
   } stamp_t;
endpackage

// File: rtl/evt_sync2.sv
`timescale 1ns/1ps
module evt_sync2 #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/evt_src_edge.sv
`timescale 1ns/1ps
module evt_src_edge
   import evt_stamp_pkg::*;
#(
   parameter int N_GPIO = 16,
   parameter int PER_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_GPIO-1:0] gpio_s,
   input  logic             soft_lvl,
   input  logic [PER_W-1:0] period,
   input  logic [SEL_W-1:0] sel,
   input  logic             rise_en,
   input  logic             fall_en,
   output logic             hit,
   output logic             hit_rise
);
   localparam int N_SRC = 1 << SEL_W;

   logic [N_SRC-1:0] src;
   logic [PER_W-1:0] tcnt;
   logic             tpulse;
   logic             lvl, prev, rise, fall;

   // periodic internal trigger: one-cycle pulse every 'period' cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt   <= '0;
         tpulse <= 1'b0;
      end else if (period == '0) begin
         tcnt   <= '0;
         tpulse <= 1'b0;
      end else if (tcnt >= period - 1'b1) begin
         tcnt   <= '0;
         tpulse <= 1'b1;
      end else begin
         tcnt   <= tcnt + 1'b1;
         tpulse <= 1'b0;
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i < N_GPIO) begin : g_pin
         assign src[i] = gpio_s[i];
      end else if (i == int'(SEL_SOFT)) begin : g_soft
         assign src[i] = soft_lvl;
      end else if (i == int'(SEL_TIMER)) begin : g_tmr
         assign src[i] = tpulse;
      end else begin : g_none
         assign src[i] = 1'b0;
      end
   end

   assign lvl = src[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise     = lvl & ~prev;
   assign fall     = ~lvl & prev;
   assign hit      = (rise & rise_en) | (fall & fall_en);
   assign hit_rise = rise;

   // R2: a rising edge cannot be seen in two consecutive cycles
   a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   // R11: with a period of two or more the timer pulse lasts one cycle
   a_r11_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tpulse && period > 1) |=> !tpulse);
endmodule

// File: rtl/evt_fifo.sv
`timescale 1ns/1ps
module evt_fifo
   import evt_stamp_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic                       pop,
   input  stamp_t                     din,
   output stamp_t                     dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evt_fifo: DEPTH must be a power of two of at least 2");
   end

   stamp_t            mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push & ~full & ~clr;
   assign do_pop  = pop & (count != '0) & ~clr;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   // R8: never more than DEPTH records
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R7: an accepted push with no pop grows the store by one
   a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !clr) |=> count == $past(count) + 1'b1);
   // R9: a flush leaves the store empty
   a_r9_clr_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/evt_stamp_slice.sv
`timescale 1ns/1ps
module evt_stamp_slice
   import evt_stamp_pkg::*;
#(
   parameter int N_GPIO = 16,
   parameter int DEPTH  = 4,
   parameter int PER_W  = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_GPIO-1:0] gpio_in,
   input  logic [31:0]       ts_sec,
   input  logic [31:0]       ts_nsec,
   input  logic [GC_W-1:0]   gcnt,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (N_GPIO < 1 || N_GPIO > 62) begin : g_bad_gpio
      $error("evt_stamp_slice: N_GPIO must be 1..62");
   end
   if (DEPTH > 32) begin : g_bad_depth
      $error("evt_stamp_slice: DEPTH must fit the 6-bit pending field");
   end
   if (PER_W < 1 || PER_W > 32 || ADDR_W < 6) begin : g_bad_width
      $error("evt_stamp_slice: PER_W or ADDR_W out of range");
   end

   logic [31:0]       cfg_q;
   logic              soft_q, ovf_q;
   logic [PER_W-1:0]  per_q;
   logic [N_GPIO-1:0] gpio_s;
   logic              hit, hit_rise, flush, pop, full;
   logic [CNT_W-1:0]  cnt;
   stamp_t            entry, head;
   logic              pending;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign flush   = wr_en & at(addr, OFS_FLUSH) & (wdata[2:0] == 3'b111);
   assign pop     = rd_en & at(addr, OFS_KIND);
   assign pending = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         soft_q <= 1'b0;
         per_q  <= '0;
      end else if (wr_en) begin
         if (at(addr, OFS_CFG))    cfg_q  <= wdata & CFG_MASK;
         if (at(addr, OFS_SOFT))   soft_q <= wdata[0];
         if (at(addr, OFS_PERIOD)) per_q  <= wdata[PER_W-1:0];
      end
   end

   evt_sync2 #(.W(N_GPIO)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s)
   );

   evt_src_edge #(.N_GPIO(N_GPIO), .PER_W(PER_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .gpio_s(gpio_s), .soft_lvl(soft_q),
      .period(per_q), .sel(cfg_q[B_SEL +: SEL_W]),
      .rise_en(cfg_q[B_RISE]), .fall_en(cfg_q[B_FALL]),
      .hit(hit), .hit_rise(hit_rise)
   );

   always_comb begin
      entry       = '0;
      entry.ts_ok = cfg_q[B_TS_EN];
      entry.gc_ok = cfg_q[B_GC_EN];
      entry.rise  = hit_rise;
      entry.sel   = cfg_q[B_SEL +: SEL_W];
      if (cfg_q[B_TS_EN]) begin
         entry.sec  = ts_sec;
         entry.nsec = ts_nsec;
      end
      if (cfg_q[B_GC_EN]) begin
         entry.gc_hi = gcnt[GC_W-1:24];
         entry.gc_lo = gcnt[23:0];
      end
   end

   evt_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(hit), .pop(pop),
      .din(entry), .dout(head), .count(cnt), .full(full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ovf_q <= 1'b0;
      else if (flush)        ovf_q <= 1'b0;
      else if (hit && full)  ovf_q <= 1'b1;
   end

   assign irq = cfg_q[B_IRQ_EN] & pending;

   always_comb begin
      rdata = '0;
      if (at(addr, OFS_CFG))    rdata = cfg_q;
      if (at(addr, OFS_STAT))   rdata = {23'd0, ovf_q, 2'd0, 6'(cnt)};
      if (at(addr, OFS_SOFT))   rdata = {31'd0, soft_q};
      if (at(addr, OFS_PERIOD)) rdata = 32'(per_q);
      if (pending) begin
         if (at(addr, OFS_TS_NS)) rdata = head.nsec;
         if (at(addr, OFS_TS_S))  rdata = head.sec;
         if (at(addr, OFS_GC_LO)) rdata = {head.gc_lo, 8'h00};
         if (at(addr, OFS_GC_HI)) rdata = head.gc_hi;
         if (at(addr, OFS_KIND))
            rdata = {14'd0, head.ts_ok, head.gc_ok, 7'd0, head.rise, 2'd0, head.sel};
      end
   end

   // R8: overflow stays set until a flush
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !flush) |=> ovf_q);
   // R8: overflow only appears when the store was full
   a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(full));
   // R9: flush clears pending status and overflow
   a_r9_flush_status: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!irq && !ovf_q));
endmodule

// File: tb/sim_evt_stamp_slice.sv
`timescale 1ns/1ps
module sim_evt_stamp_slice;
   localparam int NG = 16;
   localparam logic [11:0] A_CFG = 12'h00, A_STAT = 12'h04, A_NS = 12'h10,
      A_S = 12'h14, A_GLO = 12'h18, A_GHI = 12'h1C, A_KIND = 12'h20,
      A_FLUSH = 12'h24, A_SOFT = 12'h28, A_PER = 12'h2C;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [NG-1:0] gpio_in = '0;
   logic [31:0]   ts_sec = 32'h100, ts_nsec = 32'd0;
   logic [55:0]   gcnt = 56'h12_3456_7800_0000;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0, rdata;
   logic          irq;

   int checks = 0, bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evt_stamp_slice u0 (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .ts_sec(ts_sec),
      .ts_nsec(ts_nsec), .gcnt(gcnt), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // free-running counters, advanced away from the active edge
   always @(negedge clk) begin
      ts_nsec <= ts_nsec + 1;
      if (ts_nsec[2:0] == 3'd7) ts_sec <= ts_sec + 1;
      gcnt <= gcnt + 56'h103;
   end

   // ---------------- behavioural reference model ----------------
   typedef struct {
      logic [31:0] s, ns, ghi, glo, kind;
   } rec_t;
   rec_t        q[$];
   logic [31:0] m_cfg = 0;
   logic        m_sw = 0, m_ovf = 0, m_tp = 0, m_prev = 0;
   int          m_per = 0, m_tc = 0;
   logic [NG-1:0] d1 = 0, d2 = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 0; m_sw = 0; m_ovf = 0; m_tp = 0; m_prev = 0;
         m_per = 0; m_tc = 0; d1 = 0; d2 = 0; q.delete();
      end else begin
         int sel;
         logic lvl, up, dn, ev, fl, was_full;
         rec_t r;
         sel = int'(m_cfg[9:4]);
         if (sel < NG)       lvl = d2[sel];
         else if (sel == 62) lvl = m_sw;
         else if (sel == 63) lvl = m_tp;
         else                lvl = 1'b0;
         up = lvl && !m_prev;
         dn = !lvl && m_prev;
         ev = (up && m_cfg[0]) || (dn && m_cfg[1]);
         fl = wr_en && addr == A_FLUSH && wdata[2:0] == 3'b111;
         was_full = (q.size() == 4);
         if (fl) begin
            q.delete(); m_ovf = 0;
         end else begin
            if (rd_en && addr == A_KIND && q.size() > 0) void'(q.pop_front());
            if (ev) begin
               if (was_full) m_ovf = 1;
               else begin
                  r.s    = m_cfg[17] ? ts_sec  : 0;
                  r.ns   = m_cfg[17] ? ts_nsec : 0;
                  r.ghi  = m_cfg[16] ? gcnt[55:24] : 0;
                  r.glo  = m_cfg[16] ? {gcnt[23:0], 8'h00} : 0;
                  r.kind = {14'd0, m_cfg[17], m_cfg[16], 7'd0, up, 2'd0, m_cfg[9:4]};
                  q.push_back(r);
               end
            end
         end
         m_prev = lvl;
         d2 = d1; d1 = gpio_in;
         if (m_per == 0) begin m_tc = 0; m_tp = 0; end
         else if (m_tc >= m_per - 1) begin m_tc = 0; m_tp = 1; end
         else begin m_tc++; m_tp = 0; end
         if (wr_en && addr == A_CFG)  m_cfg = wdata & 32'h8003_03F3;
         if (wr_en && addr == A_SOFT) m_sw = wdata[0];
         if (wr_en && addr == A_PER)  m_per = int'(wdata[15:0]);
      end
   end

   function automatic logic [31:0] m_read(input logic [11:0] a);
      logic e;
      e = (q.size() == 0);
      case (a)
         A_CFG:  return m_cfg;
         A_STAT: return {23'd0, m_ovf, 8'(q.size())};
         A_SOFT: return {31'd0, m_sw};
         A_PER:  return 32'(m_per);
         A_NS:   return e ? 0 : q[0].ns;
         A_S:    return e ? 0 : q[0].s;
         A_GLO:  return e ? 0 : q[0].glo;
         A_GHI:  return e ? 0 : q[0].ghi;
         A_KIND: return e ? 0 : q[0].kind;
         default: return 0;
      endcase
   endfunction

   // ---------------- check helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // R6: interrupt compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #3 chk("R6 irq", {31'd0, irq}, {31'd0, (m_cfg[31] && q.size() > 0)});
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string req, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #2 v = rdata;
      chk(req, v, m_read(a));
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int pin);
      @(negedge clk); gpio_in[pin] = 1'b1;
      idle(4);
      gpio_in[pin] = 1'b0;
      idle(4);
   endtask

   task automatic drain(input string req);
      logic [31:0] v;
      for (int k = 0; k < 5; k++) begin
         rd(A_NS, req, v); rd(A_S, req, v);
         rd(A_GLO, req, v); rd(A_GHI, req, v);
         rd(A_KIND, req, v);
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, n0, n1;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(A_CFG, "R1", v);  chk("R1 cfg", v, 32'd0);
      rd(A_STAT, "R1", v); chk("R1 stat", v, 32'd0);
      rd(A_NS, "R1", v);   rd(A_GHI, "R1", v);
      rd(A_KIND, "R1", v); chk("R1 kind", v, 32'd0);

      // R2: rising edge on pin 3, both stamps, interrupt enabled
      wr(A_CFG, 32'h8003_0031);
      pulse(3);
      rd(A_STAT, "R2", v); chk("R2 one record", v, 32'd1);
      rd(A_NS, "R2", v); rd(A_S, "R2", v);
      rd(A_GLO, "R5", v); chk("R5 low byte zero", {24'd0, v[7:0]}, 32'd0);
      rd(A_GHI, "R5", v);
      rd(A_KIND, "R3", v); chk("R3 rise flag", {31'd0, v[8]}, 32'd1);
      rd(A_STAT, "R7", v); chk("R7 popped", v, 32'd0);

      // R3: falling edges only on pin 3
      wr(A_CFG, 32'h8003_0032);
      pulse(3);
      rd(A_STAT, "R3", v); chk("R3 one record", v, 32'd1);
      rd(A_KIND, "R3", v); chk("R3 fall flag", v, 32'h0003_0003);

      // R4: stamp enables one at a time on pin 5
      wr(A_CFG, 32'h8002_0051);
      pulse(5);
      drain("R4");
      wr(A_CFG, 32'h8001_0051);
      pulse(5);
      drain("R4");

      // R6: pending with interrupt disabled keeps irq low
      wr(A_CFG, 32'h0003_0051);
      pulse(5);
      chk("R6 masked", {31'd0, irq}, 32'd0);
      rd(A_STAT, "R6", v); chk("R6 pending", v, 32'd1);
      drain("R6");

      // R8 / R7: six edges into a four-deep store
      wr(A_CFG, 32'h8003_0071);
      for (int k = 0; k < 6; k++) pulse(7);
      rd(A_STAT, "R8", v); chk("R8 full and overflow", v, 32'h0000_0104);
      drain("R7");
      rd(A_STAT, "R8", v); chk("R8 overflow sticky", v, 32'h0000_0100);

      // R9: wrong code ignored, right code flushes
      pulse(7);
      wr(A_FLUSH, 32'h3);
      rd(A_STAT, "R9", v); chk("R9 ignored code", v, 32'h0000_0101);
      wr(A_FLUSH, 32'h7);
      rd(A_STAT, "R9", v); chk("R9 flushed", v, 32'd0);

      // R10: software trigger level
      wr(A_CFG, 32'h8003_03E1);
      wr(A_SOFT, 32'h1);
      idle(2);
      wr(A_SOFT, 32'h0);
      rd(A_STAT, "R10", v); chk("R10 one record", v, 32'd1);
      rd(A_KIND, "R10", v); chk("R10 kind", v, 32'h0003_013E);

      // R11: timer trigger with period 5, overlapping reads
      wr(A_PER, 32'd5);
      wr(A_CFG, 32'h8003_03F1);
      idle(40);
      rd(A_STAT, "R11", v);
      rd(A_NS, "R11", n0); rd(A_KIND, "R11", v);
      rd(A_NS, "R11", n1);
      chk("R11 spacing", n1 - n0, 32'd5);
      drain("R11");
      wr(A_PER, 32'd0);
      wr(A_FLUSH, 32'h7);
      idle(20);
      rd(A_STAT, "R11", v); chk("R11 stopped", v, 32'd0);

      // R12: unassigned select value never fires
      wr(A_CFG, 32'h8003_0281);
      gpio_in = '1;
      wr(A_SOFT, 32'h1);
      idle(6);
      gpio_in = '0;
      wr(A_SOFT, 32'h0);
      idle(6);
      rd(A_STAT, "R12", v); chk("R12 nothing", v, 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule